// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block sits beside the fetch stage of a small processor and repeats a stretch of code without any branch instructions. A loop command gives it a first address, a last address and an iteration count. From then on it compares every prefetch address against the address just before the loop's last instruction. On a match it either sends fetch back to the first address or lets fetch run on past the loop, depending on the remaining count. It also keeps a 3-bit nesting level and an active flag taken from that level.

One inner loop can run inside an outer loop with no help from software. A single bank of shadow registers holds the outer loop's first address, last address and count while the inner loop runs. The bank is copied back when the inner loop finishes at level two. Deeper nesting relies on software saving the three loop registers through the register port. Software can also request an early exit, which lets the pass in progress finish and then ends the loop.

Top module: `zol_ctrl`

## Requirements
- R1: After reset the level is 000, active is 0, and neither redirect_valid nor ovf_err is asserted.
- R2: A loop command at level 000 loads the three loop registers from the command fields, sets the level to 001 and sets active.
- R3: A loop command at a level from 001 to 110 first copies the current first address, last address and count into the shadow bank, then loads the command fields and raises the level by one. Active stays set.
- R4: A loop that ends while the level is 010 reloads the first address, last address and count from the shadow bank, and the level becomes 001.
- R5: Active equals the OR of the three level bits. With nested loops it falls only when the outermost loop ends.
- R6: A match happens only when active is set, pf_valid is high and pf_addr equals the stored last address minus one. Any other prefetch address gives no redirect, so a loop left by a plain branch stays active.
- R7: The count holds the number of iterations minus one. At a match with a nonzero count, redirect_valid is raised in the same cycle with redirect_addr set to the first address, and the count drops by one. At a match with a zero count there is no redirect and the level drops by one.
- R8: Writing 1 to bit 0 of the control register (select 3) while active makes the next match fall through and end the loop, whatever the count. A write made in the same cycle as a match takes effect only at the following match, so one more full pass runs.
- R9: Bit 0 of the control register always reads 0, and writing 0 to it has no effect. Bits 3:1 of the control read give the level.
- R10: Register select 0 is the first address, 1 the last address, 2 the count and 3 control. sw_rdata shows the selected register in the same cycle. A write to selects 0 to 2 is applied only in a cycle with no loop command and no match.
- R11: A loop that ends at a level above 010 only lowers the level. The loop registers are not restored.
- R12: A loop command at level 111 is ignored: the level and the loop registers keep their values, and ovf_err is high for the following cycle.
- R13: When a loop command and a match with a nonzero count occur in the same cycle, the command is taken. The redirect for the outer loop is still issued, and the shadow count receives the decremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Loop command issued this cycle |
| cmd_start | input | ADDR_W | First address of the loop body |
| cmd_end | input | ADDR_W | Address of the last instruction of the body |
| cmd_count | input | CNT_W | Iterations minus one |
| pf_valid | input | 1 | Prefetch address valid |
| pf_addr | input | ADDR_W | Current prefetch address |
| redirect_valid | output | 1 | Send fetch back to the loop start |
| redirect_addr | output | ADDR_W | Target of the redirect |
| sw_we | input | 1 | Register write strobe |
| sw_sel | input | 2 | Register select |
| sw_wdata | input | ADDR_W | Register write data |
| sw_rdata | output | ADDR_W | Selected register contents |
| level | output | 3 | Current nesting level |
| active | output | 1 | A loop is in progress |
| ovf_err | output | 1 | Loop command rejected at level 111 |

## Verification
The bench builds the sequencer with a 12-bit address and a 6-bit count. Loop bodies a few words long at distinct addresses can then be written as literal constants, and a count can be run down to zero within a handful of matches. With the 6-bit count, a software write of the all-ones value is checked at its full width. The level range is fixed at three bits, so the bench pushes eight commands to reach the saturation case, and pushes three levels to show the difference between ending at level two and ending above it.

// File: rtl/zol_pkg.sv
// Package: shared constants and the register select encoding for the
// zero-overhead loop sequencer. Assumes a fixed 3-bit nesting level.
package zol_pkg;
    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_ZERO = 3'd0;
    localparam logic [LVL_W-1:0] LVL_TWO  = 3'd2;
    localparam logic [LVL_W-1:0] LVL_MAX  = 3'd7;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_END   = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_CTRL  = 2'd3
    } zol_sel_e;
endpackage

// File: rtl/zol_match.sv
// Module: zol_match
// Decides, in the same cycle, whether the prefetch address hits the
// loop's penultimate address and whether that hit repeats or ends the
// loop. Purely combinational. Assumes end_q holds the last body address.
module zol_match #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              active,
    input  logic              pf_valid,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic [ADDR_W-1:0] start_q,
    input  logic [ADDR_W-1:0] end_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              term_q,
    output logic              hit,
    output logic              redir,
    output logic              loop_end,
    output logic [ADDR_W-1:0] redir_addr
);
    logic [ADDR_W-1:0] penult;
    logic              cnt_zero;

    // Compare prefetch against penultimate address and classify the hit.
    always_comb begin
        penult     = end_q - ADDR_W'(1);
        cnt_zero   = (cnt_q == '0);
        hit        = active && pf_valid && (pf_addr == penult);
        redir      = hit && !cnt_zero && !term_q;
        loop_end   = hit && (cnt_zero || term_q);
        redir_addr = start_q;
    end
endmodule

// File: rtl/zol_level.sv
// Module: zol_level
// Tracks the 3-bit nesting level, saturating at its top value, and
// flags a loop command that arrives when no level is left.
// Assumes push and pop are never both requested (caller gives push priority).
module zol_level
    import zol_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             push,
    input  logic             pop,
    output logic [LVL_W-1:0] level_q,
    output logic             at_max,
    output logic             active,
    output logic             ovf_q
);
    // Status decode taken from the level register.
    always_comb begin
        at_max = (level_q == LVL_MAX);
        active = |level_q;
    end

    // Level counter: up on accepted command, down on loop end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= LVL_ZERO;
        end else if (push) begin
            level_q <= level_q + 3'd1;
        end else if (pop && level_q != LVL_ZERO) begin
            level_q <= level_q - 3'd1;
        end
    end

    // Overflow flag: one cycle after a command rejected at full level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= cmd_valid && at_max;
        end
    end
endmodule

// File: rtl/zol_regbank.sv
// Module: zol_regbank
// Holds the live loop registers (first address, last address, count),
// their single shadow bank, and the software write and read path.
// Update priority: push, then restore, then decrement, then software write.
// Assumes CNT_W is not wider than ADDR_W.
module zol_regbank
    import zol_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              restore,
    input  logic              dec,
    input  logic              cap_dec,
    input  logic [ADDR_W-1:0] cmd_start,
    input  logic [ADDR_W-1:0] cmd_end,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              wr_en,
    input  zol_sel_e          wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [ADDR_W-1:0] sh_start,
    output logic [ADDR_W-1:0] sh_end,
    output logic [CNT_W-1:0]  sh_cnt
);
    logic [CNT_W-1:0] cnt_less;

    // Count minus one, shared by decrement and shadow capture.
    always_comb begin
        cnt_less = cnt_q - CNT_W'(1);
    end

    // Live loop registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            cnt_q   <= '0;
        end else if (push) begin
            start_q <= cmd_start;
            end_q   <= cmd_end;
            cnt_q   <= cmd_count;
        end else if (restore) begin
            start_q <= sh_start;
            end_q   <= sh_end;
            cnt_q   <= sh_cnt;
        end else if (dec) begin
            cnt_q   <= cnt_less;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_START: start_q <= wr_data;
                SEL_END:   end_q   <= wr_data;
                SEL_COUNT: cnt_q   <= wr_data[CNT_W-1:0];
                default:   ;
            endcase
        end
    end

    // Shadow bank: captures live values when a loop is pushed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_start <= '0;
            sh_end   <= '0;
            sh_cnt   <= '0;
        end else if (push) begin
            sh_start <= start_q;
            sh_end   <= end_q;
            sh_cnt   <= cap_dec ? cnt_less : cnt_q;
        end
    end
endmodule

// File: rtl/zol_ctrl.sv
// Module: zol_ctrl (top)
// Zero-overhead loop sequencer for a fetch stage. Holds one loop frame
// plus one shadow frame, tracks a 3-bit nesting level, redirects fetch
// at the penultimate body address, and honours an early-exit request.
// Assumes a loop command is already decoded and one prefetch address is
// presented per cycle. The redirect is combinational from pf_addr.
module zol_ctrl
    import zol_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_start,
    input  logic [ADDR_W-1:0] cmd_end,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              pf_valid,
    input  logic [ADDR_W-1:0] pf_addr,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr,
    input  logic              sw_we,
    input  logic [1:0]        sw_sel,
    input  logic [ADDR_W-1:0] sw_wdata,
    output logic [ADDR_W-1:0] sw_rdata,
    output logic [2:0]        level,
    output logic              active,
    output logic              ovf_err
);
    zol_sel_e          sel;
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] end_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] sh_start;
    logic [ADDR_W-1:0] sh_end;
    logic [CNT_W-1:0]  sh_cnt;
    logic [LVL_W-1:0]  level_q;
    logic              at_max;
    logic              term_q;
    logic              hit;
    logic              redir;
    logic              loop_end;
    logic              push;
    logic              pop;
    logic              restore;
    logic              dec;
    logic              data_we;
    logic              term_set;

    // Control decode: command priority over the match, then software.
    always_comb begin
        sel      = zol_sel_e'(sw_sel);
        push     = cmd_valid && !at_max;
        pop      = loop_end && !push;
        restore  = pop && (level_q == LVL_TWO);
        dec      = redir && !push;
        data_we  = sw_we && !cmd_valid && !hit && (sel != SEL_CTRL);
        term_set = sw_we && (sel == SEL_CTRL) && sw_wdata[0] && active;
    end

    // Early-exit request: set by software, consumed when a loop ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q <= 1'b0;
        end else if (loop_end) begin
            term_q <= 1'b0;
        end else if (term_set) begin
            term_q <= 1'b1;
        end
    end

    // Register read mux; the early-exit bit always reads as zero.
    always_comb begin
        case (sel)
            SEL_START: sw_rdata = start_q;
            SEL_END:   sw_rdata = end_q;
            SEL_COUNT: sw_rdata = ADDR_W'(cnt_q);
            default:   sw_rdata = ADDR_W'({level_q, 1'b0});
        endcase
    end

    zol_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
        .active     (active),
        .pf_valid   (pf_valid),
        .pf_addr    (pf_addr),
        .start_q    (start_q),
        .end_q      (end_q),
        .cnt_q      (cnt_q),
        .term_q     (term_q),
        .hit        (hit),
        .redir      (redir),
        .loop_end   (loop_end),
        .redir_addr (redirect_addr)
    );

    zol_level u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .push      (push),
        .pop       (pop),
        .level_q   (level_q),
        .at_max    (at_max),
        .active    (active),
        .ovf_q     (ovf_err)
    );

    zol_regbank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .restore   (restore),
        .dec       (dec),
        .cap_dec   (redir),
        .cmd_start (cmd_start),
        .cmd_end   (cmd_end),
        .cmd_count (cmd_count),
        .wr_en     (data_we),
        .wr_sel    (sel),
        .wr_data   (sw_wdata),
        .start_q   (start_q),
        .end_q     (end_q),
        .cnt_q     (cnt_q),
        .sh_start  (sh_start),
        .sh_end    (sh_end),
        .sh_cnt    (sh_cnt)
    );

    // Drive the status outputs from the level tracker.
    always_comb begin
        level          = level_q;
        redirect_valid = redir;
    end
endmodule

// File: rtl/zol_ctrl_chk.sv
// Module: zol_ctrl_chk
// Checker for zol_ctrl: temporal properties on level, shadow and redirect
// behaviour. Attached to every zol_ctrl instance by the bind below.
module zol_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [ADDR_W-1:0] cmd_start,
    input logic [2:0]        level,
    input logic              active,
    input logic              redirect_valid,
    input logic              ovf_err,
    input logic [ADDR_W-1:0] start_q,
    input logic [ADDR_W-1:0] sh_start,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              hit,
    input logic              loop_end,
    input logic              term_q
);
    assert_first_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && level == 3'd0) |=> (level == 3'd1 && active));

    assert_push_shadow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && level != 3'd0 && level != 3'd7)
        |=> (sh_start == $past(start_q) && start_q == $past(cmd_start)
             && level == $past(level) + 3'd1));

    assert_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_end && !cmd_valid && level == 3'd2)
        |=> (start_q == $past(sh_start) && level == 3'd1));

    assert_active_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(level) == 3'd1));

    assert_redir_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (active && hit));

    assert_count_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !cmd_valid) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_term_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && term_q) |-> (!redirect_valid && loop_end));

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && level == 3'd7) |=> (level == 3'd7 && ovf_err));
endmodule

bind zol_ctrl zol_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_start      (cmd_start),
    .level          (level),
    .active         (active),
    .redirect_valid (redirect_valid),
    .ovf_err        (ovf_err),
    .start_q        (start_q),
    .sh_start       (sh_start),
    .cnt_q          (cnt_q),
    .hit            (hit),
    .loop_end       (loop_end),
    .term_q         (term_q)
);

// File: tb/zol_ctrl_bench.sv
// Directed bench for zol_ctrl: one task per scenario, each checking itself.
module zol_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_start = '0;
    logic [AW-1:0] cmd_end = '0;
    logic [CW-1:0] cmd_count = '0;
    logic          pf_valid = 1'b0;
    logic [AW-1:0] pf_addr = '0;
    logic          redirect_valid;
    logic [AW-1:0] redirect_addr;
    logic          sw_we = 1'b0;
    logic [1:0]    sw_sel = 2'd0;
    logic [AW-1:0] sw_wdata = '0;
    logic [AW-1:0] sw_rdata;
    logic [2:0]    level;
    logic          active;
    logic          ovf_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zol_ctrl #(.ADDR_W(AW), .CNT_W(CW)) u_zol_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_end(cmd_end),
        .cmd_count(cmd_count), .pf_valid(pf_valid), .pf_addr(pf_addr),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .level(level), .active(active), .ovf_err(ovf_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        cmd_valid = 0; pf_valid = 0; sw_we = 0;
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic issue(input logic [AW-1:0] s, input logic [AW-1:0] e, input logic [CW-1:0] c);
        cmd_valid = 1; cmd_start = s; cmd_end = e; cmd_count = c;
        tick();
        cmd_valid = 0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [AW-1:0] v);
        sw_sel = sel;
        #1;
        v = sw_rdata;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
        sw_we = 1; sw_sel = sel; sw_wdata = d;
        tick();
        sw_we = 0;
    endtask

    // Present a prefetch address and sample the combinational redirect.
    task automatic fetch(input logic [AW-1:0] a, output logic rv, output logic [AW-1:0] ra);
        pf_valid = 1; pf_addr = a;
        #1;
        rv = redirect_valid; ra = redirect_addr;
    endtask

    task automatic t_reset();
        logic [AW-1:0] v;
        do_reset();
        check("R1 level", level, 0);
        check("R1 active", active, 0);
        check("R1 redirect", redirect_valid, 0);
        check("R1 ovf", ovf_err, 0);
        rd(2'd3, v);
        check("R1 ctrl read", v, 0);
    endtask

    task automatic t_single();
        logic rv; logic [AW-1:0] ra, v;
        do_reset();
        issue(12'h010, 12'h014, 6'd2);
        check("R2 level", level, 1);
        check("R2 active", active, 1);
        rd(2'd0, v); check("R2 start", v, 12'h010);
        rd(2'd1, v); check("R2 end", v, 12'h014);
        fetch(12'h014, rv, ra);
        check("R6 no hit on last addr", rv, 0);
        fetch(12'h013, rv, ra);
        check("R7 redirect 1", rv, 1);
        check("R7 redirect addr", ra, 12'h010);
        tick();
        rd(2'd2, v); check("R7 count after dec", v, 1);
        fetch(12'h013, rv, ra);
        check("R7 redirect 2", rv, 1);
        tick();
        fetch(12'h013, rv, ra);
        check("R7 fall through", rv, 0);
        tick();
        pf_valid = 0;
        check("R7 level down", level, 0);
        check("R5 active clear", active, 0);
    endtask

    task automatic t_nested();
        logic rv; logic [AW-1:0] ra, v;
        do_reset();
        issue(12'h020, 12'h030, 6'd1);
        issue(12'h022, 12'h026, 6'd0);
        check("R3 level two", level, 2);
        check("R3 active kept", active, 1);
        rd(2'd0, v); check("R3 new start", v, 12'h022);
        fetch(12'h025, rv, ra);
        check("R7 inner ends", rv, 0);
        tick();
        pf_valid = 0;
        check("R4 level one", level, 1);
        check("R5 active stays", active, 1);
        rd(2'd0, v); check("R4 start restored", v, 12'h020);
        rd(2'd1, v); check("R4 end restored", v, 12'h030);
        rd(2'd2, v); check("R4 count restored", v, 1);
        fetch(12'h02F, rv, ra);
        check("R4 outer redirect", rv, 1);
        check("R4 outer addr", ra, 12'h020);
        tick();
        fetch(12'h02F, rv, ra);
        tick();
        pf_valid = 0;
        check("R5 outer ends clears", active, 0);
    endtask

    task automatic t_deep();
        logic rv; logic [AW-1:0] ra, v;
        do_reset();
        issue(12'h100, 12'h110, 6'd0);
        issue(12'h200, 12'h210, 6'd0);
        issue(12'h300, 12'h310, 6'd0);
        check("R3 level three", level, 3);
        fetch(12'h30F, rv, ra);
        tick();
        pf_valid = 0;
        check("R11 level two", level, 2);
        rd(2'd0, v); check("R11 no restore", v, 12'h300);
        fetch(12'h30F, rv, ra);
        tick();
        pf_valid = 0;
        check("R4 level one after", level, 1);
        rd(2'd0, v); check("R4 restore shadow", v, 12'h200);
    endtask

    task automatic t_overflow();
        logic [AW-1:0] v;
        do_reset();
        for (int i = 0; i < 7; i++) issue(AW'(12'h100 + 16*i), AW'(12'h108 + 16*i), 6'd3);
        check("R12 level max", level, 7);
        check("R12 no ovf yet", ovf_err, 0);
        issue(12'h800, 12'h808, 6'd9);
        check("R12 level held", level, 7);
        check("R12 ovf pulse", ovf_err, 1);
        rd(2'd0, v); check("R12 regs kept", v, 12'h160);
        tick();
        check("R12 ovf one cycle", ovf_err, 0);
    endtask

    task automatic t_terminate();
        logic rv; logic [AW-1:0] ra, v;
        do_reset();
        issue(12'h060, 12'h068, 6'd5);
        wr(2'd3, 12'h001);
        rd(2'd3, v);
        check("R9 ctrl reads level only", v, 12'h002);
        fetch(12'h067, rv, ra);
        check("R8 early exit no redirect", rv, 0);
        tick();
        pf_valid = 0;
        check("R8 loop ended", level, 0);
        issue(12'h060, 12'h068, 6'd1);
        wr(2'd3, 12'h000);
        fetch(12'h067, rv, ra);
        check("R9 write zero no effect", rv, 1);
        tick();
        pf_valid = 0;
        // write lands on the penultimate fetch itself
        do_reset();
        issue(12'h070, 12'h078, 6'd5);
        sw_we = 1; sw_sel = 2'd3; sw_wdata = 12'h001;
        fetch(12'h077, rv, ra);
        check("R8 same-cycle write still repeats", rv, 1);
        tick();
        sw_we = 0; pf_valid = 0;
        tick();
        fetch(12'h077, rv, ra);
        check("R8 next pass ends", rv, 0);
        tick();
        pf_valid = 0;
        check("R8 level after extra pass", level, 0);
    endtask

    task automatic t_coincide();
        logic rv; logic [AW-1:0] ra, v;
        do_reset();
        issue(12'h040, 12'h050, 6'd3);
        cmd_valid = 1; cmd_start = 12'h044; cmd_end = 12'h048; cmd_count = 6'd1;
        fetch(12'h04F, rv, ra);
        check("R13 outer redirect kept", rv, 1);
        check("R13 outer addr", ra, 12'h040);
        tick();
        cmd_valid = 0; pf_valid = 0;
        check("R13 command taken", level, 2);
        rd(2'd2, v); check("R13 inner count", v, 1);
        fetch(12'h047, rv, ra);
        tick();
        fetch(12'h047, rv, ra);
        tick();
        pf_valid = 0;
        rd(2'd2, v); check("R13 shadow count decremented", v, 2);
        rd(2'd0, v); check("R13 outer start back", v, 12'h040);
    endtask

    task automatic t_software();
        logic rv; logic [AW-1:0] ra, v;
        do_reset();
        wr(2'd0, 12'hABC);
        rd(2'd0, v); check("R10 start write", v, 12'hABC);
        wr(2'd2, 12'hFFF);
        rd(2'd2, v); check("R10 count width", v, 12'h03F);
        issue(12'h080, 12'h088, 6'd3);
        sw_we = 1; sw_sel = 2'd0; sw_wdata = 12'h555;
        fetch(12'h087, rv, ra);
        tick();
        sw_we = 0; pf_valid = 0;
        rd(2'd0, v); check("R10 write blocked on match", v, 12'h080);
        fetch(12'h100, rv, ra);
        check("R6 branch out no redirect", rv, 0);
        tick();
        pf_valid = 0;
        check("R6 active after branch out", active, 1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_nested();
        t_deep();
        t_overflow();
        t_terminate();
        t_coincide();
        t_software();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule